// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Read Responder

This block is the device side of a serial EEPROM that software drives by writing bits into registers, with no real pins. The host writes a control register that holds a chip-select bit and a serial-clock bit, and a data register that holds one data bit. The responder watches each control write for a 0-to-1 change of the clock bit. Only such a change moves the protocol forward.

After select rises, the first clock edge takes the start bit. The next eight edges shift a command in, most significant bit first, using the data bit the host left in the data register. A command with its top bit set is a read. Its low seven bits form a word address, which is doubled to index an internal byte array. The byte at the even address and the byte after it form a big-endian 16-bit word. Each later clock edge places the next bit of that word in the data register, most significant bit first, where the host reads it back. The byte array is a fixed table loaded at reset, and its first six bytes hold the station MAC address. Write and erase commands are not executed. They set a sticky error flag instead.

Top module: `eep_bitbang_resp`

## Requirements
- R1: After reset the machine is idle, and `dat_out`, `err_unsup` and `warn_overrun` are all 0.
- R2: A control write with `ctl_sel`=0 puts the machine in idle at once, including in the middle of a read. In idle, clock edges leave `dat_out` unchanged.
- R3: Only a control write whose `ctl_sck` is 1 while the previously written `ctl_sck` was 0 counts as a clock edge. Writing 1 twice in a row counts once.
- R4: After select rises from 0 to 1, the first clock edge consumes the start bit whatever its value and begins command collection.
- R5: Eight command edges each shift the current data-register bit into the command, MSB first. With command bit 7 = 1, the word is {byte[2*A], byte[2*A+1]}, where A is command bits 6..0.
- R6: Each read edge places the next word bit, MSB first, on `dat_out`. It is visible in the cycle after the write.
- R7: After the 16th data bit, further read edges drive `dat_out` to 0 until select drops.
- R8: The 17th and every later read edge set `warn_overrun`, which stays 1 until reset.
- R9: A command with bit 7 = 0 sets `err_unsup`, which stays 1 until reset, and returns the machine to idle.
- R10: Byte i of the array is MAC byte i (MAC bits 47..40 first) for i<6. For i≥6 it is the low 8 bits of i*37+11.
- R11: A data-register write sets `dat_out` to `dat_in` one cycle later. If a read edge happens in the same cycle, the read edge's bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Select bit written to the control register |
| ctl_sck | input | 1 | Serial clock bit written to the control register |
| dat_we | input | 1 | Data register write strobe |
| dat_in | input | 1 | Data bit written by the host |
| dat_out | output | 1 | Data register contents (host bit or shifted-out EEPROM bit) |
| err_unsup | output | 1 | Sticky flag: a non-read command was received |
| warn_overrun | output | 1 | Sticky flag: more than 16 data bits were clocked out |

## Verification
Every result is registered. It appears in the cycle after the write strobe that caused it: for `dat_out` after a clock-edge or data write, and for `err_unsup` after the eighth command edge and `warn_overrun` after the seventeenth read edge. The driver applies each write at a falling edge and drops the strobe at the next falling edge, so the rising edge between them is the one that captures the write. When a read edge completes, the driver pushes the expected bit into a queue. It then signals the monitor, which pops that bit and compares it with `dat_out` at that same falling edge, one cycle after the write. The sticky flags are sampled at the same point, both just before and just after the edge that should set them.

// File: rtl/eep_resp_pkg.sv
package eep_resp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READY = 2'd1,
      ST_CMD   = 2'd2,
      ST_READ  = 2'd3
   } eep_state_e;

   localparam int WORD_W = 16;

   // Preload value of one array byte: MAC bytes first, then a computed fill.
   function automatic logic [7:0] fill_byte(int unsigned idx, logic [47:0] mac);
      logic [47:0] sh;
      if (idx < 6) begin
         sh = mac << (8 * idx);
         return sh[47:40];
      end
      return 8'((idx * 37 + 11) & 255);
   endfunction

endpackage

// File: rtl/eep_ctl_edge.sv
module eep_ctl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic sel_in,
   input  logic sck_in,
   output logic desel,
   output logic sel_rise,
   output logic sck_rise
);
   logic sel_q;
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         sck_q <= 1'b0;
      end else if (we) begin
         sel_q <= sel_in;
         sck_q <= sck_in;
      end
   end

   assign desel    = we & ~sel_in;
   assign sel_rise = we & sel_in & ~sel_q;
   assign sck_rise = we & sck_in & ~sck_q;

   // R3
   sck_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> sck_q);

   // R3
   sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(sck_q) && $stable(sel_q));

endmodule

// File: rtl/eep_rom.sv
module eep_rom #(
   parameter int          ADDR_BITS = 7,
   parameter logic [47:0] MAC       = 48'h021A2B3C4D5E,
   parameter bit          FLOP_ROM  = 1'b0,
   localparam int         BA_W      = ADDR_BITS + 1,
   localparam int         BYTES     = 1 << BA_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BA_W-1:0] byte_addr,
   output logic [15:0]     word
);
   import eep_resp_pkg::*;

   logic [BA_W-1:0] odd_addr;
   assign odd_addr = byte_addr | BA_W'(1);

   generate
      if (FLOP_ROM) begin : g_flop
         logic [7:0] mem [BYTES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < BYTES; i++)
                  mem[i] <= fill_byte(i, MAC);
            end
         end
         assign word = {mem[byte_addr], mem[odd_addr]};
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign word = {fill_byte(int'(byte_addr), MAC),
                        fill_byte(int'(odd_addr), MAC)};
      end
   endgenerate

endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
   parameter int  ADDR_BITS = 7,
   localparam int CMD_W     = ADDR_BITS + 1,
   localparam int WORD_W    = eep_resp_pkg::WORD_W,
   localparam int CNT_W     = $clog2(2 * WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             desel,
   input  logic             sel_rise,
   input  logic             sck_rise,
   input  logic             dat_we,
   input  logic             dat_in,
   input  logic [15:0]      rom_word,
   output logic [CMD_W-1:0] rom_addr,
   output logic             dat_out,
   output logic             err_out,
   output logic             warn_out
);
   import eep_resp_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] WORD_END = CNT_W'(WORD_W);

   eep_state_e       st_q, st_n, st_eff;
   logic [CMD_W-1:0] cmd_q, cmd_n, cmd_shift;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [15:0]      word_q, word_n;
   logic             dat_q, dat_n, err_q, err_n, warn_q, warn_n;

   assign cmd_shift = {cmd_q[CMD_W-2:0], dat_q};
   assign rom_addr  = {cmd_shift[CMD_W-2:0], 1'b0};

   always_comb begin
      st_eff = st_q;
      if (desel)         st_eff = ST_IDLE;
      else if (sel_rise) st_eff = ST_READY;
      st_n   = st_eff;
      cmd_n  = cmd_q;
      cnt_n  = cnt_q;
      word_n = word_q;
      dat_n  = dat_we ? dat_in : dat_q;
      err_n  = err_q;
      warn_n = warn_q;
      if (sck_rise) begin
         case (st_eff)
            ST_READY: begin
               st_n  = ST_CMD;
               cnt_n = '0;
            end
            ST_CMD: begin
               cmd_n = cmd_shift;
               cnt_n = cnt_q + 1'b1;
               if (cnt_q == CMD_LAST) begin
                  if (cmd_shift[CMD_W-1]) begin
                     st_n   = ST_READ;
                     cnt_n  = '0;
                     word_n = rom_word;
                  end else begin
                     st_n  = ST_IDLE;
                     err_n = 1'b1;
                  end
               end
            end
            ST_READ: begin
               dat_n  = word_q[15];
               word_n = {word_q[14:0], 1'b0};
               if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
               if (cnt_q >= WORD_END) warn_n = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cmd_q  <= '0;
         cnt_q  <= '0;
         word_q <= '0;
         dat_q  <= 1'b0;
         err_q  <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         cmd_q  <= cmd_n;
         cnt_q  <= cnt_n;
         word_q <= word_n;
         dat_q  <= dat_n;
         err_q  <= err_n;
         warn_q <= warn_n;
      end
   end

   assign dat_out  = dat_q;
   assign err_out  = err_q;
   assign warn_out = warn_q;

   // R2
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desel |=> st_q == ST_IDLE);

   // R4
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_READY && sck_rise && !desel) |=> st_q == ST_CMD);

   // R7
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_READ && cnt_q >= WORD_END && sck_rise && !desel) |=> !dat_q);

   // R8
   warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warn_q |=> warn_q);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R11
   dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !dat_we) |=> $stable(dat_q));

endmodule

// File: rtl/eep_bitbang_resp.sv
module eep_bitbang_resp #(
   parameter int          ADDR_BITS = 7,
   parameter logic [47:0] MAC       = 48'h021A2B3C4D5E,
   parameter bit          FLOP_ROM  = 1'b0,
   localparam int         CMD_W     = ADDR_BITS + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_we,
   input  logic ctl_sel,
   input  logic ctl_sck,
   input  logic dat_we,
   input  logic dat_in,
   output logic dat_out,
   output logic err_unsup,
   output logic warn_overrun
);
   generate
      if (ADDR_BITS < 1 || ADDR_BITS > 10) begin : g_bad_addr
         $error("eep_bitbang_resp: ADDR_BITS must be within 1..10");
      end
   endgenerate

   logic             desel, sel_rise, sck_rise;
   logic [CMD_W-1:0] rom_addr;
   logic [15:0]      rom_word;

   eep_ctl_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl_we),
      .sel_in   (ctl_sel),
      .sck_in   (ctl_sck),
      .desel    (desel),
      .sel_rise (sel_rise),
      .sck_rise (sck_rise)
   );

   eep_rom #(
      .ADDR_BITS (ADDR_BITS),
      .MAC       (MAC),
      .FLOP_ROM  (FLOP_ROM)
   ) u_rom (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_addr (rom_addr),
      .word      (rom_word)
   );

   eep_seq #(
      .ADDR_BITS (ADDR_BITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .desel    (desel),
      .sel_rise (sel_rise),
      .sck_rise (sck_rise),
      .dat_we   (dat_we),
      .dat_in   (dat_in),
      .rom_word (rom_word),
      .rom_addr (rom_addr),
      .dat_out  (dat_out),
      .err_out  (err_unsup),
      .warn_out (warn_overrun)
   );

endmodule

// File: tb/eep_bitbang_resp_bench.sv
module eep_bitbang_resp_bench;
   localparam logic [47:0] MAC = 48'h021A2B3C4D5E;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 1'b0, ctl_sel = 1'b0, ctl_sck = 1'b0;
   logic dat_we = 1'b0, dat_in = 1'b0;
   logic dat_out, err_unsup, warn_overrun;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic  exp_q[$];
   string req_q[$];
   event  smp_ev;

   always #5 clk = ~clk;

   eep_bitbang_resp #(.MAC(MAC)) u_eep_bitbang_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_sel      (ctl_sel),
      .ctl_sck      (ctl_sck),
      .dat_we       (dat_we),
      .dat_in       (dat_in),
      .dat_out      (dat_out),
      .err_unsup    (err_unsup),
      .warn_overrun (warn_overrun)
   );

   task automatic chk(string req, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_byte(int i);
      logic [47:0] s;
      if (i < 6) begin
         s = MAC << (8 * i);
         return s[47:40];
      end
      return 8'((i * 37 + 11) % 256);
   endfunction

   function automatic logic [15:0] exp_word(int a);
      return {exp_byte(2 * a), exp_byte(2 * a + 1)};
   endfunction

   // Monitor: pops one expected data bit per read edge and compares it.
   initial begin
      forever begin
         @(smp_ev);
         if (exp_q.size() != 0) chk(req_q.pop_front(), dat_out, exp_q.pop_front());
      end
   end

   task automatic wr_ctl(logic s, logic k);
      @(negedge clk);
      ctl_we = 1'b1; ctl_sel = s; ctl_sck = k;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_dat(logic b);
      @(negedge clk);
      dat_we = 1'b1; dat_in = b;
      @(negedge clk);
      dat_we = 1'b0;
   endtask

   task automatic start_cmd(logic startb, logic [7:0] cmd, bit dup);
      wr_ctl(1'b0, 1'b0);
      wr_ctl(1'b1, 1'b0);
      wr_dat(startb);
      wr_ctl(1'b1, 1'b1);
      for (int k = 7; k >= 0; k--) begin
         wr_ctl(1'b1, 1'b0);
         wr_dat(cmd[k]);
         wr_ctl(1'b1, 1'b1);
         if (dup) wr_ctl(1'b1, 1'b1);
      end
   endtask

   task automatic clock_out(int first, int n, logic [15:0] w, string req);
      for (int i = first; i < first + n; i++) begin
         wr_ctl(1'b1, 1'b0);
         wr_ctl(1'b1, 1'b1);
         exp_q.push_back(i < 16 ? w[15 - i] : 1'b0);
         req_q.push_back(req);
         -> smp_ev;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 dat_out", dat_out, 1'b0);
      chk("R1 err", err_unsup, 1'b0);
      chk("R1 warn", warn_overrun, 1'b0);

      // R11 host data writes in idle
      wr_dat(1'b1); chk("R11 idle write 1", dat_out, 1'b1);
      wr_dat(1'b0); chk("R11 idle write 0", dat_out, 1'b0);

      // R5 R6 R10: MAC word, start bit 1
      start_cmd(1'b1, {1'b1, 7'd0}, 1'b0);
      clock_out(0, 16, exp_word(0), "R10 R6 word0");
      // R4: start bit value 0 also accepted
      start_cmd(1'b0, {1'b1, 7'd2}, 1'b0);
      clock_out(0, 16, exp_word(2), "R4 R10 word2");
      start_cmd(1'b1, {1'b1, 7'd63}, 1'b0);
      clock_out(0, 16, exp_word(63), "R5 word63");
      // R3: repeated clock-high writes count once
      start_cmd(1'b1, {1'b1, 7'd127}, 1'b1);
      clock_out(0, 16, exp_word(127), "R3 R5 word127");

      // R2: drop select mid-read, then clock edges have no effect
      start_cmd(1'b1, {1'b1, 7'd1}, 1'b0);
      clock_out(0, 5, exp_word(1), "R2 prefix word1");
      wr_ctl(1'b0, 1'b0);
      wr_dat(1'b1);
      wr_ctl(1'b0, 1'b1); wr_ctl(1'b0, 1'b0); wr_ctl(1'b0, 1'b1);
      chk("R2 idle after deselect", dat_out, 1'b1);
      wr_dat(1'b0);
      wr_ctl(1'b0, 1'b0); wr_ctl(1'b0, 1'b1);
      chk("R2 idle stays 0", dat_out, 1'b0);
      start_cmd(1'b1, {1'b1, 7'd5}, 1'b0);
      clock_out(0, 16, exp_word(5), "R2 restart word5");

      // R11: read edge and host write in the same cycle, read bit wins
      start_cmd(1'b1, {1'b1, 7'd3}, 1'b0);
      wr_ctl(1'b1, 1'b0);
      @(negedge clk);
      ctl_we = 1'b1; ctl_sel = 1'b1; ctl_sck = 1'b1;
      dat_we = 1'b1; dat_in = ~exp_word(3)[15];
      @(negedge clk);
      ctl_we = 1'b0; dat_we = 1'b0;
      chk("R11 read edge wins", dat_out, exp_word(3)[15]);
      clock_out(1, 15, exp_word(3), "R6 word3");

      // R7 R8: over-clocking
      start_cmd(1'b1, {1'b1, 7'd10}, 1'b0);
      clock_out(0, 16, exp_word(10), "R6 word10");
      chk("R8 no warn at 16", warn_overrun, 1'b0);
      clock_out(16, 1, exp_word(10), "R7 bit17 zero");
      chk("R8 warn at 17", warn_overrun, 1'b1);
      clock_out(17, 2, exp_word(10), "R7 tail zero");
      wr_ctl(1'b0, 1'b0);
      chk("R8 warn sticky", warn_overrun, 1'b1);

      // R9: non-read command
      chk("R9 err clear before", err_unsup, 1'b0);
      start_cmd(1'b1, 8'h05, 1'b0);
      chk("R9 err set", err_unsup, 1'b1);
      wr_dat(1'b1);
      wr_ctl(1'b1, 1'b0); wr_ctl(1'b1, 1'b1);
      chk("R9 idle keeps host bit 1", dat_out, 1'b1);
      wr_dat(1'b0);
      wr_ctl(1'b1, 1'b0); wr_ctl(1'b1, 1'b1);
      chk("R9 idle keeps host bit 0", dat_out, 1'b0);
      start_cmd(1'b1, {1'b1, 7'd4}, 1'b0);
      clock_out(0, 16, exp_word(4), "R9 read after error");
      chk("R9 err sticky", err_unsup, 1'b1);

      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule